// File: doc/BRIEF.md
# Clock Frequency Measurement Counter

This block measures how fast a clock under test runs by counting its rising edges during a fixed window of reference ticks. The reference is a slow, steady time base; nominally it is a crystal clock divided by four, ticking at 4.8 MHz. Software first writes the window length into the control word with the enable bit clear. This stops the counters and loads the window. Software then writes the same length with the enable bit set to start a run, and polls the status word until the done flag rises. It then reads the edge count and converts it to hertz itself.

The block spans three clock domains: the bus clock, the reference clock and the measured clock. The run request reaches the reference domain through a two-flop synchronizer, and from there the measured domain through a second one. The done event returns to the bus domain through a synchronizer. The count is sampled into the bus domain only once done is seen, so the value software reads is stable. Only the measured clock's own logic clears the edge counter. When that clock is stopped, a new run returns the previous count unchanged, and software can detect a dead clock by comparing a short run with a long one.

Top module: `clk_freq_meter`

## Requirements
- R1: While the reset input is low, and just after it is released, the status word reads all zeros: done flag 0 and count 0.
- R2: A control write with bit 20 clear stops the run and loads bits 19:0 as the window length. Within 15 bus cycles of that write the done flag (status bit 25) reads 0.
- R3: A control write with bit 20 set starts a run. Done never rises before the window's reference ticks have elapsed. It rises no later than 30 bus cycles after they have elapsed, and stays 1 until the next stop write.
- R4: Status bits 24:0 hold the number of measured-clock rising edges counted during the window, within ±4 edges of window × f_meas / f_ref. The rate estimate ((count·10)+15)·f_ref / ((window·10)+35) lies within 0.5% of the true measured rate.
- R5: While done reads 1, the count field does not change. The count field and the done flag change in the same bus cycle.
- R6: If the measured clock is stopped, a new run of any window returns the count left by the previous run. A short run and a long run therefore give equal counts.
- R7: Once the measured clock runs again, the next stop-then-start sequence clears the counter and returns a fresh count.
- R8: The edge counter saturates at all ones and does not wrap. Below saturation, a narrow counter reports the same count as a wide one.
- R9: A window of 0 ticks still completes with done = 1 and a count of 0.
- R10: Windows of both 0x1000 and 0x10000 ticks are supported with the R4 accuracy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus clock for the control and status words |
| rst_n | input | 1 | Asynchronous active-low reset for the bus and reference domains |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 21 | Control word: bits 19:0 window length in reference ticks, bit 20 run enable |
| stat_rdata | output | 32 | Status word: bits 24:0 edge count, bit 25 done, upper bits zero |
| ref_clk | input | 1 | Reference time base (crystal divided by four) |
| meas_clk | input | 1 | Clock under test |

## Verification
After a stop write, the done flag drops about six bus cycles later: one bus register, two reference synchronizer stages plus the done register, then three bus stages. The bench allows 15 cycles for this. After a start write, done rises after the window plus about thirteen bus cycles of synchronizer and settle delay. A per-cycle model in the bench knows the start cycle and the window, and on every falling bus edge it enforces both the earliest and the latest cycle at which done may rise. The bench reads the count three bus cycles after it sees done. On every cycle in which done is held, the model also confirms that the count field equals its value from the previous cycle.

// File: rtl/clk_freq_meter.sv
module clk_freq_meter #(
  parameter int WIN_W  = 20,
  parameter int CNT_W  = 25,
  parameter int SETTLE = 8,
  parameter int STAT_W = 32
) (
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [WIN_W:0]    ctl_wdata,
  output logic [STAT_W-1:0] stat_rdata,
  input  logic              ref_clk,
  input  logic              meas_clk
);
  localparam int EN_BIT = WIN_W;
  localparam int SET_W  = $clog2(SETTLE + 1);
  localparam int PAD_W  = STAT_W - CNT_W - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // bus domain: control word
  logic [WIN_W-1:0] win_q;
  logic             run_q;

  always_ff @(posedge bus_clk or negedge rst_n)
    if (!rst_n) begin
      win_q <= '0;
      run_q <= 1'b0;
    end else if (ctl_we) begin
      win_q <= ctl_wdata[WIN_W-1:0];
      run_q <= ctl_wdata[EN_BIT];
    end

  // reference domain: window countdown and settle
  logic             run_s1, run_r;
  logic [WIN_W-1:0] tick_q;
  logic             gate_q, expired_q, done_q;
  logic [SET_W-1:0] settle_q;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      run_s1    <= 1'b0;
      run_r     <= 1'b0;
      tick_q    <= '0;
      gate_q    <= 1'b0;
      expired_q <= 1'b0;
      done_q    <= 1'b0;
      settle_q  <= '0;
    end else begin
      run_s1 <= run_q;
      run_r  <= run_s1;
      if (!run_r) begin
        tick_q    <= win_q;
        gate_q    <= 1'b0;
        expired_q <= 1'b0;
        done_q    <= 1'b0;
        settle_q  <= '0;
      end else if (!expired_q) begin
        if (tick_q == '0) begin
          expired_q <= 1'b1;
          gate_q    <= 1'b0;
        end else begin
          tick_q <= tick_q - 1'b1;
          gate_q <= 1'b1;
        end
      end else begin
        gate_q <= 1'b0;
        if (settle_q == SET_W'(SETTLE)) done_q <= 1'b1;
        else settle_q <= settle_q + 1'b1;
      end
    end

  // measured domain: edge counter, cleared only by its own clock
  logic [1:0]       arm_sy, gate_sy;
  logic [CNT_W-1:0] mcnt;
  wire              arm_m  = arm_sy[1];
  wire              gate_m = gate_sy[1];

  always_ff @(posedge meas_clk) begin
    arm_sy  <= {arm_sy[0], run_r};
    gate_sy <= {gate_sy[0], gate_q};
    if (!arm_m) mcnt <= '0;
    else if (gate_m && mcnt != CNT_MAX) mcnt <= mcnt + 1'b1;
  end

  // bus domain: done synchronizer and count capture
  logic [2:0]       done_sy;
  logic [CNT_W-1:0] cnt_b;

  always_ff @(posedge bus_clk or negedge rst_n)
    if (!rst_n) begin
      done_sy <= '0;
      cnt_b   <= '0;
    end else begin
      done_sy <= {done_sy[1:0], done_q};
      if (done_sy[1] && !done_sy[2]) cnt_b <= mcnt;
    end

  assign stat_rdata = {{PAD_W{1'b0}}, done_sy[2], cnt_b};

  // R3
  gate_done_excl_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(gate_q && done_q));

  // R2
  stop_clears_done_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !run_r |=> !done_q);

  // R8
  sat_hold_chk: assert property (@(posedge meas_clk) disable iff (!rst_n)
    (arm_m && mcnt == CNT_MAX) |=> mcnt == CNT_MAX);

  // R4
  count_mono_chk: assert property (@(posedge meas_clk) disable iff (!rst_n)
    arm_m |=> mcnt >= $past(mcnt));

  // R5
  read_stable_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    done_sy[2] |=> $stable(cnt_b));
endmodule

// File: tb/tb_clk_freq_meter.sv
module tb_clk_freq_meter;
  logic        bus_clk = 0, ref_clk = 0, meas_clk = 0, meas_on = 1;
  logic        rst_n = 0, ctl_we = 0;
  logic [20:0] ctl_wdata = '0;
  logic [31:0] stat, stat_sat;

  always #5 bus_clk = ~bus_clk;
  always #4 ref_clk = ~ref_clk;
  always #3 if (meas_on) meas_clk = ~meas_clk;

  clk_freq_meter dut (.bus_clk(bus_clk), .rst_n(rst_n), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .stat_rdata(stat), .ref_clk(ref_clk), .meas_clk(meas_clk));

  clk_freq_meter #(.CNT_W(10)) dut_sat (.bus_clk(bus_clk), .rst_n(rst_n), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .stat_rdata(stat_sat), .ref_clk(ref_clk), .meas_clk(meas_clk));

  int     total = 0, bad = 0;
  longint cyc = 0, start_cyc = 0;
  int     phase = 0, win_n = 0;
  bit     prev_done = 0, finished = 0;
  logic [24:0] prev_cnt = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic real est_rate(input int c, input int n);
    return (c * 10.0 + 15.0) * 125.0e6 / (n * 10.0 + 35.0);
  endfunction

  // per-cycle reference model: done timing window and read stability
  always @(negedge bus_clk) begin
    longint el, lo, hi;
    cyc++;
    if (rst_n && !finished) begin
      if (phase == 1) begin
        el = cyc - start_cyc;
        lo = longint'(win_n) * 8 / 10;
        hi = lo + 30;
        if (el < lo) chk(stat[25] == 1'b0, "R3 done too early", stat[25], 0);
        if (el > hi) chk(stat[25] == 1'b1, "R3 done too late", stat[25], 1);
      end
      if (stat[25] && prev_done)
        chk(stat[24:0] == prev_cnt, "R5 count moved while done", stat[24:0], prev_cnt);
      prev_done = stat[25];
      prev_cnt  = stat[24:0];
    end
    if (cyc > 190000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic bus_wr(input logic [20:0] d);
    @(posedge bus_clk); #1 ctl_we = 1; ctl_wdata = d;
    @(posedge bus_clk); #1 ctl_we = 0;
  endtask

  task automatic do_run(input int n, output int c);
    phase = 0;
    bus_wr(21'(n));
    repeat (15) @(negedge bus_clk);
    chk(stat[25] == 1'b0, "R2 done cleared after stop", stat[25], 0);
    win_n = n;
    bus_wr(21'(n) | 21'h100000);
    start_cyc = cyc;
    phase = 1;
    for (int i = 0; i < n + 200 && !stat[25]; i++) @(negedge bus_clk);
    chk(stat[25] == 1'b1, "R3 done raised", stat[25], 1);
    repeat (3) @(negedge bus_clk);
    c = int'(stat[24:0]);
  endtask

  task automatic chk_count(input int c, input int n, input string req);
    int  d;
    real r, t;
    d = c * 3 - n * 4;
    chk(d <= 12 && d >= -12, req, c, n * 4 / 3);
    r = est_rate(c, n);
    t = 1.0e9 / 6.0;
    chk((r - t) / t < 0.005 && (t - r) / t < 0.005, {req, " rate kHz"},
        longint'(r / 1000.0), longint'(t / 1000.0));
  endtask

  initial begin
    int c1, c2, c0, cf, cs, cf2, cr;
    repeat (5) @(negedge bus_clk);
    chk(stat == 32'd0, "R1 status in reset", stat, 0);
    chk(stat_sat == 32'd0, "R1 narrow status in reset", stat_sat, 0);
    rst_n = 1;
    repeat (3) @(negedge bus_clk);
    chk(stat == 32'd0, "R1 status after reset", stat, 0);

    do_run(4096, c1);
    chk_count(c1, 4096, "R4 R10 short window");
    chk(stat_sat[10] == 1'b1 && stat_sat[9:0] == 10'h3FF, "R8 saturated", stat_sat[9:0], 1023);

    do_run(512, c2);
    chk_count(c2, 512, "R4 small window");
    chk(c2 < 1023 && int'(stat_sat[9:0]) == c2, "R8 below saturation", stat_sat[9:0], c2);

    do_run(0, c0);
    chk(c0 == 0, "R9 zero window count", c0, 0);

    do_run(65536, cf);
    chk_count(cf, 65536, "R10 full window");

    meas_on = 0;
    do_run(4096, cs);
    chk(cs == cf, "R6 stale count short", cs, cf);
    do_run(65536, cf2);
    chk(cf2 == cs, "R6 short equals full", cf2, cs);

    meas_on = 1;
    do_run(4096, cr);
    chk_count(cr, 4096, "R7 fresh count");
    chk(cr != cf, "R7 counter cleared", cr, c1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule